// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Register Block

This block is the register and interrupt front end of a two-channel serial controller whose channels are called A and B. A host reaches it through a simple synchronous register bus. The bus has an address, separate read and write strobes, and 8-bit write and read data. The block has no line logic of its own, so baud generation, bit shifting, FIFOs and mode decoding sit elsewhere. On each channel it sees three inputs: a pulse marking the arrival of a character, a level saying that a character is waiting, and the waiting byte. On each channel it drives the transmitted byte together with a one-cycle strobe.

One 8-bit interrupt status register and one 8-bit interrupt mask register are shared by both channels. Channel A owns the low nibble and channel B owns the high nibble. Each register can be reached at three addresses: a full view, and two per-channel nibble views that read or replace only one half. Status bits are not written directly. They change as side effects of three things: character arrival, accesses to the data registers, and a periodic transmit-ready tick. A single registered, level-sensitive interrupt line is set by those events. It is dropped by reading the channel A line-status register.

Top module: `dual_serial_irq_regs`

## Requirements
- R1: After synchronous active-low reset, all of the following read as zero: the status register, the mask register, the irq output, the read data, both transmit strobes and both transmit data outputs. The internal tick phase also restarts.
- R2: Status bit layout is as follows. Bit 0 is A transmit ready, bit 1 is A receive ready, bit 4 is B transmit ready and bit 5 is B receive ready. The full status reads at 0x390. The A view at 0x320 returns bits 3:0. The B view at 0x340 returns bits 7:4 in bits 3:0 with zeros above. Writes to all three status addresses are ignored.
- R3: The mask uses the same bit layout as the status. It reads and writes in full at 0x3A0. The A view at 0x330 reads bits 3:0, and a write there replaces only bits 3:0. The B view at 0x350 reads bits 7:4 in bits 3:0, and a write there moves data bits 3:0 into mask bits 7:4. Each view write leaves the other nibble unchanged.
- R4: A pulse on rx_arrive[c] sets channel c's receive-ready status bit, and sets irq on the next edge. This happens only when that channel's receive mask bit (1 for A, 5 for B) was already set before the edge. With the mask bit clear, the arrival changes nothing.
- R5: A read of 0x160 (A) or 0x260 (B) returns that channel's rx byte and clears its receive-ready bit. If a masked-in arrival on the same channel happens in the same cycle, the arrival wins and the bit stays set.
- R6: A write to 0x170 (A) or 0x270 (B) clears that channel's transmit-ready bit. In the next cycle it presents the byte on tx_data_a or tx_data_b with tx_stb bit 0 (A) or bit 1 (B) high for one cycle. The data output holds its value until the next write.
- R7: Every second tick pulse sets both transmit-ready bits (0 and 4) and sets irq, provided mask bit 0 or 4 is set at that time. Odd ticks do nothing visible, but they still advance the phase even while the mask is clear. If a tick set and a transmit-data write land in the same cycle, the set wins.
- R8: A read of 0x120 (A) or 0x220 (B) returns bit 0 as that channel's rx_avail level and bit 2 as 1, with all other bits 0. An A read clears irq unless a set event happens in the same cycle, and set wins. A B read leaves irq alone.
- R9: A read of any unmapped address returns 0. A write to an unmapped or read-only address changes no status, no mask, no irq and no transmit output.
- R10: Read data is registered. It appears in the cycle after bus_rd and holds until the next read. bus_rd and bus_wr are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_arrive | input | 2 | Character-arrival pulse, bit 0 = A, bit 1 = B |
| rx_avail | input | 2 | Character-waiting level, bit 0 = A, bit 1 = B |
| rx_data_a | input | 8 | Waiting byte, channel A |
| rx_data_b | input | 8 | Waiting byte, channel B |
| tick | input | 1 | Periodic one-cycle pulse |
| tx_stb | output | 2 | Transmit strobe, bit 0 = A, bit 1 = B |
| tx_data_a | output | 8 | Transmitted byte, channel A |
| tx_data_b | output | 8 | Transmitted byte, channel B |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest situations to reach are same-cycle collisions between a set source and a clear source. Examples are an arrival together with a read of the same channel's data register, a tick together with a transmit-data write, and either set event together with a channel A status read. The random stream drives tick, arrival and bus operations independently every cycle, so such overlaps occur often. Directed steps first arm the mask and place the tick phase one pulse away from firing, and then force each collision once.

// File: rtl/dsi_pkg.sv
// Package: shared offsets, bit positions and the decoded-select type for the
// dual-channel serial interrupt register block.
package dsi_pkg;
    localparam int OFS_W = 12;

    localparam logic [OFS_W-1:0] OFS_ISR_ALL = 12'h390;
    localparam logic [OFS_W-1:0] OFS_ISR_A   = 12'h320;
    localparam logic [OFS_W-1:0] OFS_ISR_B   = 12'h340;
    localparam logic [OFS_W-1:0] OFS_IMR_ALL = 12'h3A0;
    localparam logic [OFS_W-1:0] OFS_IMR_A   = 12'h330;
    localparam logic [OFS_W-1:0] OFS_IMR_B   = 12'h350;
    localparam logic [OFS_W-1:0] OFS_RXD_A   = 12'h160;
    localparam logic [OFS_W-1:0] OFS_RXD_B   = 12'h260;
    localparam logic [OFS_W-1:0] OFS_TXD_A   = 12'h170;
    localparam logic [OFS_W-1:0] OFS_TXD_B   = 12'h270;
    localparam logic [OFS_W-1:0] OFS_LSR_A   = 12'h120;
    localparam logic [OFS_W-1:0] OFS_LSR_B   = 12'h220;

    // Bit positions inside one channel nibble
    localparam int NIB_TX = 0;
    localparam int NIB_RX = 1;

    typedef struct packed {
        logic isr_all;
        logic isr_a;
        logic isr_b;
        logic imr_all;
        logic imr_a;
        logic imr_b;
        logic rxd_a;
        logic rxd_b;
        logic txd_a;
        logic txd_b;
        logic lsr_a;
        logic lsr_b;
    } reg_sel_t;
endpackage

// File: rtl/dsi_decode.sv
// Module: dsi_decode
// Purpose: turns a bus address into one select flag per mapped register and
// a hit flag. Assumes ADDR_W is at least dsi_pkg::OFS_W; upper bits must be 0.
module dsi_decode
    import dsi_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel,
    output logic              hit
);
    // Compare the address against every mapped offset
    always_comb begin
        sel.isr_all = (addr == ADDR_W'(OFS_ISR_ALL));
        sel.isr_a   = (addr == ADDR_W'(OFS_ISR_A));
        sel.isr_b   = (addr == ADDR_W'(OFS_ISR_B));
        sel.imr_all = (addr == ADDR_W'(OFS_IMR_ALL));
        sel.imr_a   = (addr == ADDR_W'(OFS_IMR_A));
        sel.imr_b   = (addr == ADDR_W'(OFS_IMR_B));
        sel.rxd_a   = (addr == ADDR_W'(OFS_RXD_A));
        sel.rxd_b   = (addr == ADDR_W'(OFS_RXD_B));
        sel.txd_a   = (addr == ADDR_W'(OFS_TXD_A));
        sel.txd_b   = (addr == ADDR_W'(OFS_TXD_B));
        sel.lsr_a   = (addr == ADDR_W'(OFS_LSR_A));
        sel.lsr_b   = (addr == ADDR_W'(OFS_LSR_B));
        hit         = |sel;
    end
endmodule

// File: rtl/dsi_tick_div.sv
// Module: dsi_tick_div
// Purpose: counts tick pulses and fires on every DIV-th one, then restarts.
// Assumes tick is a one-cycle pulse and DIV >= 2.
module dsi_tick_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic fire
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase;

    // Fire when the tick lands on the last phase
    assign fire = tick && (phase == LAST);

    // Advance the phase on each tick, wrapping after the last one
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (tick)
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end

    // R7: two firings are never in adjacent cycles
    a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
    // R7: an idle cycle leaves the phase alone
    a_r7_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase));
endmodule

// File: rtl/dsi_chan.sv
// Module: dsi_chan
// Purpose: one channel's nibble of interrupt status and mask. It holds the
// transmit-ready and receive-ready bits, and requests an interrupt on a
// masked-in arrival. Assumes rx_evt, rx_rd, tx_wr and tx_fire are pulses.
module dsi_chan
    import dsi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mask_we,
    input  logic [3:0] mask_wdata,
    input  logic       rx_evt,
    input  logic       rx_rd,
    input  logic       tx_wr,
    input  logic       tx_fire,
    output logic [3:0] stat,
    output logic [3:0] mask,
    output logic       irq_req
);
    logic rx_rdy;
    logic tx_rdy;

    // An arrival counts only if the receive mask bit is already set
    assign irq_req = rx_evt && mask[NIB_RX];

    // Status nibble as seen by the bus
    always_comb begin
        stat         = '0;
        stat[NIB_TX] = tx_rdy;
        stat[NIB_RX] = rx_rdy;
    end

    // Receive-ready: an arrival set wins over a data-read clear
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_rdy <= 1'b0;
        else if (irq_req) rx_rdy <= 1'b1;
        else if (rx_rd)   rx_rdy <= 1'b0;
    end

    // Transmit-ready: a tick set wins over a data-write clear
    always_ff @(posedge clk) begin
        if (!rst_n)       tx_rdy <= 1'b0;
        else if (tx_fire) tx_rdy <= 1'b1;
        else if (tx_wr)   tx_rdy <= 1'b0;
    end

    // Mask nibble storage
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= mask_wdata;
    end

    // R4: a masked-in arrival sets receive-ready
    a_r4_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt && mask[NIB_RX]) |=> stat[NIB_RX]);
    // R4: a masked-out arrival cannot raise receive-ready
    a_r4_rx_masked_out: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt && !mask[NIB_RX] && !stat[NIB_RX]) |=> !stat[NIB_RX]);
    // R5: a data read with no arrival clears receive-ready
    a_r5_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !rx_evt) |=> !stat[NIB_RX]);
    // R6: a data write with no tick set clears transmit-ready
    a_r6_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !tx_fire) |=> !stat[NIB_TX]);
    // R3: the mask changes only when written
    a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask));
endmodule

// File: rtl/dual_serial_irq_regs.sv
// Module: dual_serial_irq_regs
// Purpose: register and interrupt front end for two serial channels. It
// holds the shared status and mask registers with full and per-channel views,
// data-register side effects, the transmit-ready tick and one registered irq.
// Assumes bus_rd and bus_wr are never high together, and that tick and
// rx_arrive are one-cycle pulses.
module dual_serial_irq_regs
    import dsi_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int TICK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [1:0]        rx_arrive,
    input  logic [1:0]        rx_avail,
    input  logic [7:0]        rx_data_a,
    input  logic [7:0]        rx_data_b,
    input  logic              tick,
    output logic [1:0]        tx_stb,
    output logic [7:0]        tx_data_a,
    output logic [7:0]        tx_data_b,
    output logic              irq
);
    localparam int NCH = 2;
    localparam int NIB = 4;

    reg_sel_t           sel;
    logic               hit;
    logic               tick_fire;
    logic               tx_fire;
    logic               set_any;
    logic [NCH-1:0]     mask_we;
    logic [NIB-1:0]     mask_wd  [NCH];
    logic [NIB-1:0]     stat_nib [NCH];
    logic [NIB-1:0]     mask_nib [NCH];
    logic [NCH-1:0]     rx_rd;
    logic [NCH-1:0]     tx_wr;
    logic [NCH-1:0]     irq_req;
    logic [7:0]         isr;
    logic [7:0]         imr;
    logic [7:0]         rd_val;

    dsi_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .sel  (sel),
        .hit  (hit)
    );

    dsi_tick_div #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .fire  (tick_fire)
    );

    // Per-channel strobes from the decoded bus operation
    always_comb begin
        rx_rd      = {bus_rd && sel.rxd_b, bus_rd && sel.rxd_a};
        tx_wr      = {bus_wr && sel.txd_b, bus_wr && sel.txd_a};
        mask_we[0] = bus_wr && (sel.imr_all || sel.imr_a);
        mask_we[1] = bus_wr && (sel.imr_all || sel.imr_b);
        mask_wd[0] = bus_wdata[3:0];
        mask_wd[1] = sel.imr_all ? bus_wdata[7:4] : bus_wdata[3:0];
    end

    // Transmit-ready fires only when either transmit mask bit is set
    assign tx_fire = tick_fire && (mask_nib[0][NIB_TX] || mask_nib[1][NIB_TX]);
    assign set_any = tx_fire || (|irq_req);

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        dsi_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .mask_we    (mask_we[c]),
            .mask_wdata (mask_wd[c]),
            .rx_evt     (rx_arrive[c]),
            .rx_rd      (rx_rd[c]),
            .tx_wr      (tx_wr[c]),
            .tx_fire    (tx_fire),
            .stat       (stat_nib[c]),
            .mask       (mask_nib[c]),
            .irq_req    (irq_req[c])
        );
    end

    assign isr = {stat_nib[1], stat_nib[0]};
    assign imr = {mask_nib[1], mask_nib[0]};

    // Read multiplexer: zero for unmapped and write-only addresses
    always_comb begin
        rd_val = '0;
        if (sel.isr_all)    rd_val = isr;
        else if (sel.isr_a) rd_val = {4'h0, isr[3:0]};
        else if (sel.isr_b) rd_val = {4'h0, isr[7:4]};
        else if (sel.imr_all) rd_val = imr;
        else if (sel.imr_a) rd_val = {4'h0, imr[3:0]};
        else if (sel.imr_b) rd_val = {4'h0, imr[7:4]};
        else if (sel.rxd_a) rd_val = rx_data_a;
        else if (sel.rxd_b) rd_val = rx_data_b;
        else if (sel.lsr_a) rd_val = {5'b0, 1'b1, 1'b0, rx_avail[0]};
        else if (sel.lsr_b) rd_val = {5'b0, 1'b1, 1'b0, rx_avail[1]};
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    // Interrupt line: any set event wins over the channel A status-read clear
    always_ff @(posedge clk) begin
        if (!rst_n)                  irq <= 1'b0;
        else if (set_any)            irq <= 1'b1;
        else if (bus_rd && sel.lsr_a) irq <= 1'b0;
    end

    // Transmit outputs: one-cycle strobe, byte held until the next write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_stb    <= '0;
            tx_data_a <= '0;
            tx_data_b <= '0;
        end else begin
            tx_stb <= tx_wr;
            if (tx_wr[0]) tx_data_a <= bus_wdata;
            if (tx_wr[1]) tx_data_b <= bus_wdata;
        end
    end

    // R4: any set event raises irq on the next edge
    a_r4_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_any |=> irq);
    // R8: channel A status read with no set event drops irq
    a_r8_lsr_a_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel.lsr_a && !set_any) |=> !irq);
    // R8: irq changes only through a set event or channel A status read
    a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_any && !(bus_rd && sel.lsr_a)) |=> $stable(irq));
    // R6: a channel A data write gives a strobe and the written byte
    a_r6_tx_a_out: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel.txd_a) |=> (tx_stb[0] && tx_data_a == $past(bus_wdata)));
    // R9: unmapped reads return zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit) |=> (bus_rdata == 8'h00));
    // R3: a channel A mask view write keeps the channel B nibble
    a_r3_view_a_keeps_b: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel.imr_a) |=> (imr[7:4] == $past(imr[7:4])));
    // R10: read data holds when no read is issued
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_dual_serial_irq_regs.sv
`timescale 1ns/1ps
module test_dual_serial_irq_regs;
    import dsi_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  rx_arrive = '0;
    logic [1:0]  rx_avail = '0;
    logic [7:0]  rx_data_a = '0;
    logic [7:0]  rx_data_b = '0;
    logic        tick = 1'b0;
    logic [1:0]  tx_stb;
    logic [7:0]  tx_data_a;
    logic [7:0]  tx_data_b;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [7:0] m_isr = '0, m_imr = '0, m_rdata = '0, m_txa = '0, m_txb = '0;
    logic       m_irq = 1'b0;
    int         m_phase = 0;

    always #2.5 clk = ~clk;

    dual_serial_irq_regs i_dual_serial_irq_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_arrive(rx_arrive), .rx_avail(rx_avail), .rx_data_a(rx_data_a),
        .rx_data_b(rx_data_b), .tick(tick), .tx_stb(tx_stb),
        .tx_data_a(tx_data_a), .tx_data_b(tx_data_b), .irq(irq)
    );

    // Expected read value from the model state and current inputs
    function automatic logic [7:0] f_read(input logic [11:0] a);
        case (a)
            OFS_ISR_ALL: return m_isr;
            OFS_ISR_A:   return {4'h0, m_isr[3:0]};
            OFS_ISR_B:   return {4'h0, m_isr[7:4]};
            OFS_IMR_ALL: return m_imr;
            OFS_IMR_A:   return {4'h0, m_imr[3:0]};
            OFS_IMR_B:   return {4'h0, m_imr[7:4]};
            OFS_RXD_A:   return rx_data_a;
            OFS_RXD_B:   return rx_data_b;
            OFS_LSR_A:   return {7'h02, rx_avail[0]};
            OFS_LSR_B:   return {7'h02, rx_avail[1]};
            default:     return 8'h00;
        endcase
    endfunction

    // Requirement tag for a read at address a
    function automatic string f_tag(input logic [11:0] a);
        case (a)
            OFS_ISR_ALL, OFS_ISR_A, OFS_ISR_B: return "R2";
            OFS_IMR_ALL, OFS_IMR_A, OFS_IMR_B: return "R3";
            OFS_RXD_A, OFS_RXD_B:              return "R5";
            OFS_LSR_A, OFS_LSR_B:              return "R8";
            default:                           return "R9";
        endcase
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle with side inputs; the model predicts the next state
    task automatic step(input logic rd, input logic wr, input logic [11:0] a,
                        input logic [7:0] wd, input logic [1:0] arr,
                        input logic tk, input string tag);
        logic [7:0] n_isr, n_imr, e_rd;
        logic       n_irq, set;
        logic [1:0] e_stb;
        string      t;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        rx_arrive = arr; tick = tk;
        rx_avail = 2'($urandom);
        rx_data_a = 8'($urandom); rx_data_b = 8'($urandom);
        n_isr = m_isr; n_imr = m_imr; set = 1'b0;
        e_rd = rd ? f_read(a) : m_rdata;
        if (rd && a == OFS_RXD_A) n_isr[1] = 1'b0;
        if (rd && a == OFS_RXD_B) n_isr[5] = 1'b0;
        if (wr && a == OFS_TXD_A) n_isr[0] = 1'b0;
        if (wr && a == OFS_TXD_B) n_isr[4] = 1'b0;
        if (wr && a == OFS_IMR_ALL) n_imr = wd;
        if (wr && a == OFS_IMR_A) n_imr[3:0] = wd[3:0];
        if (wr && a == OFS_IMR_B) n_imr[7:4] = wd[3:0];
        if (tk) begin
            if (m_phase == 1) begin
                m_phase = 0;
                if (m_imr[0] || m_imr[4]) begin
                    n_isr[0] = 1'b1; n_isr[4] = 1'b1; set = 1'b1;
                end
            end else m_phase = 1;
        end
        if (arr[0] && m_imr[1]) begin n_isr[1] = 1'b1; set = 1'b1; end
        if (arr[1] && m_imr[5]) begin n_isr[5] = 1'b1; set = 1'b1; end
        n_irq = set ? 1'b1 : ((rd && a == OFS_LSR_A) ? 1'b0 : m_irq);
        e_stb = {wr && a == OFS_TXD_B, wr && a == OFS_TXD_A};
        if (e_stb[0]) m_txa = wd;
        if (e_stb[1]) m_txb = wd;
        @(posedge clk);
        #1;
        t = (tag != "") ? tag : (rd ? f_tag(a) : "R10");
        check8(t, bus_rdata, e_rd);
        t = (tag != "") ? tag : (set ? (tk ? "R7" : "R4") : "R8");
        check8(t, {7'h0, irq}, {7'h0, n_irq});
        t = (tag != "") ? tag : "R6";
        check8(t, {6'h0, tx_stb}, {6'h0, e_stb});
        check8(t, tx_data_a, m_txa);
        check8(t, tx_data_b, m_txb);
        m_isr = n_isr; m_imr = n_imr; m_irq = n_irq; m_rdata = e_rd;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] addrs [12];
        void'($urandom(32'd24681));
        addrs = '{OFS_ISR_ALL, OFS_ISR_A, OFS_ISR_B, OFS_IMR_ALL, OFS_IMR_A,
                  OFS_IMR_B, OFS_RXD_A, OFS_RXD_B, OFS_TXD_A, OFS_TXD_B,
                  OFS_LSR_A, OFS_LSR_B};
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state at the ports
        #1;
        check8("R1", bus_rdata, 8'h00);
        check8("R1", {7'h0, irq}, 8'h00);
        check8("R1", {6'h0, tx_stb}, 8'h00);
        check8("R1", tx_data_a, 8'h00);
        step(1, 0, OFS_ISR_ALL, 0, 0, 0, "R1");
        step(1, 0, OFS_IMR_ALL, 0, 0, 0, "R1");
        // R4: arrival with the mask clear changes nothing
        step(0, 0, 12'h000, 0, 2'b11, 0, "R4");
        step(1, 0, OFS_ISR_ALL, 0, 0, 0, "R4");
        // R3: nibble view writes keep the other half
        step(0, 1, OFS_IMR_ALL, 8'h5A, 0, 0, "R3");
        step(0, 1, OFS_IMR_A, 8'hF3, 0, 0, "R3");
        step(0, 1, OFS_IMR_B, 8'hE2, 0, 0, "R3");
        step(1, 0, OFS_IMR_ALL, 0, 0, 0, "R3");
        step(1, 0, OFS_IMR_B, 0, 0, 0, "R3");
        // R9: writes to read-only and unmapped offsets are ignored
        step(0, 1, OFS_ISR_ALL, 8'hFF, 0, 0, "R9");
        step(0, 1, 12'h7F0, 8'hFF, 0, 0, "R9");
        step(1, 0, OFS_IMR_ALL, 0, 0, 0, "R9");
        step(1, 0, 12'h7F0, 0, 0, 0, "R9");
        // R5: arrival and data read in the same cycle; the arrival wins
        step(0, 1, OFS_IMR_ALL, 8'h33, 0, 0, "R4");
        step(1, 0, OFS_RXD_A, 0, 2'b01, 0, "R5");
        step(1, 0, OFS_ISR_A, 0, 0, 0, "R5");
        step(1, 0, OFS_RXD_A, 0, 0, 0, "R5");
        step(1, 0, OFS_ISR_A, 0, 0, 0, "R5");
        // R8: channel B status read keeps irq; channel A status read drops it
        step(1, 0, OFS_LSR_B, 0, 0, 0, "R8");
        step(1, 0, OFS_LSR_A, 0, 0, 0, "R8");
        // R7: odd tick is silent; even tick with a TX write on the same cycle
        step(0, 0, 12'h000, 0, 0, 1, "R7");
        step(0, 1, OFS_TXD_B, 8'hA5, 0, 1, "R7");
        step(1, 0, OFS_ISR_ALL, 0, 0, 0, "R7");
        // R8: set event collides with a channel A status read
        step(1, 0, OFS_LSR_A, 0, 2'b10, 0, "R8");
        // R6: transmit write clears its bit
        step(0, 1, OFS_TXD_A, 8'h3C, 0, 0, "R6");
        step(1, 0, OFS_ISR_ALL, 0, 0, 0, "R6");
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [11:0] a;
            op = int'($urandom % 10);
            a = ($urandom % 8 == 0) ? 12'($urandom) : addrs[$urandom % 12];
            step(op < 5, (op >= 5) && (op < 8), a, 8'($urandom),
                 {($urandom % 6) == 0, ($urandom % 6) == 0},
                 ($urandom % 3) == 0, "");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule